// File: doc/BRIEF.md
# Debug Register Scan Access Port

This block is the data-register side of a debug access path. A TAP controller outside the block supplies strobes for Capture-DR, Shift-DR and Update-DR, all synchronous to the test clock. The block turns them into accesses to a small bank of on-chip debug registers. Each scan moves a 38-bit word through the chain, least significant bit first. The low 32 bits are the data field, bits 36:32 are the register address and bit 37 is the direction flag.

A write completes within a single scan. At Update-DR the data field is masked to the implemented width of the addressed register and is handed to the bank together with a one-hot write strobe. A read takes two scans. Update-DR with the flag clear only stores the address. The following Capture-DR raises a one-hot read strobe for the stored address and loads the masked register value into the data field.

Some registers have side effects when they are read. For that reason the stored read address comes out of reset pointing at the comms control register, which has none. A host can steer a final read scan to that register in the same way.

Top module: `dbg_scan_port`

## Requirements
- R1: The chain is 38 bits long and shifts from tdi toward tdo, least significant bit first. Bits 31:0 hold data, bits 36:32 hold the address and bit 37 is the flag (1 = write, 0 = read). After 38 shift cycles the word shifted in sits in the chain, and its bit 0 is on tdo.
- R2: An Update-DR with the flag at 1 and a mapped address drives wr_strb_o with only the bit for that address set, in the cycle after the update edge. In the same cycle wr_data_o carries the data field masked to that register's width.
- R3: A write to an unmapped address raises no write strobe. With the default parameters the unmapped addresses are 3, 6, 7, 14, 15 and 22 to 31.
- R4: An Update-DR with the flag at 0 raises no write strobe and places the address on rd_addr_o. The next Capture-DR loads the masked rd_data_i into bits 31:0 of the chain and zeros into bits 37:32.
- R5: During the cycle of a Capture-DR event, rd_strb_o has only the bit of the stored read address set. If that address is unmapped, rd_strb_o stays zero and the data field captures zero.
- R6: After reset, tdo is 0, no strobe is active and rd_addr_o is 4 (comms control). A capture made before any read update therefore returns register 4.
- R7: Each Capture-DR or Update-DR event gives at most one single-cycle strobe and one capture, even when the TAP strobe is held for several cycles.
- R8: The implemented widths with the default parameters are as follows. Address 0 (debug control) is 6 bits, 1 (status) is 5, 2 (vector catch) is 8, 4 is 6 and 5 is 32. Each watch unit, based at 8 and at 16, has 32-bit registers at offsets 0 to 3, 9 bits at offset 4 and 8 bits at offset 5. Bits above a register's width are written as zero and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_dr | input | 1 | Capture-DR state indication from the TAP |
| shift_dr | input | 1 | Shift-DR state indication from the TAP |
| upd_dr | input | 1 | Update-DR state indication from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| rd_addr_o | output | ADDR_W (5) | Stored read address, steers the bank's read mux |
| rd_strb_o | output | 2**ADDR_W (32) | One-hot read strobe, live in the capture cycle |
| rd_data_i | input | DATA_W (32) | Read data of the register at rd_addr_o |
| wr_strb_o | output | 2**ADDR_W (32) | One-hot single-cycle write strobe |
| wr_data_o | output | DATA_W (32) | Width-masked write data |

## Verification
The hardest case to reach is a read whose data belongs to a register that was written just before. The answer arrives one scan late, and by then the bank has changed and the stored address may have been moved. The bench keeps its own copy of the bank and of the stored address across long random runs of mixed read and write scans. The bank is preloaded with full 32-bit patterns, so every capture also tests the upper-bit masking. Directed scans hold Capture-DR and Update-DR for several cycles, and they aim reads and writes at holes in the map.

// File: rtl/dsap_pkg.sv
package dsap_pkg;

   localparam int unsigned WATCH_STRIDE = 8;
   localparam int unsigned SAFE_SLOT    = 4;

   // Implemented width of the register at one address; 0 marks a hole.
   function automatic int unsigned slot_width(input int unsigned addr,
                                              input int unsigned ctrl_w,
                                              input int unsigned stat_w,
                                              input bit          has_vec,
                                              input int unsigned n_watch);
      int unsigned unit;
      int unsigned ofs;
      unit = addr / WATCH_STRIDE;
      ofs  = addr % WATCH_STRIDE;
      if (unit >= 1 && unit <= n_watch) begin
         if (ofs < 4)       return 32;
         else if (ofs == 4) return 9;
         else if (ofs == 5) return 8;
         else               return 0;
      end
      case (addr)
         0:       return ctrl_w;
         1:       return stat_w;
         2:       return has_vec ? 8 : 0;
         4:       return 6;
         5:       return 32;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] low_ones(input int unsigned w);
      if (w >= 64) return '1;
      return (64'd1 << w) - 64'd1;
   endfunction

endpackage

// File: rtl/dsap_pulse.sv
module dsap_pulse #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] evt
);
   logic [N-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign evt = lvl & ~lvl_q;
endmodule

// File: rtl/dsap_shift.sv
module dsap_shift #(
   parameter int unsigned CHAIN_W = 38
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_evt,
   input  logic               shift_en,
   input  logic               tdi,
   input  logic [CHAIN_W-1:0] cap_val,
   output logic [CHAIN_W-1:0] chain_q,
   output logic               tdo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chain_q <= '0;
      else if (cap_evt)  chain_q <= cap_val;
      else if (shift_en) chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
   end

   assign tdo = chain_q[0];
endmodule

// File: rtl/dsap_map.sv
module dsap_map
   import dsap_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CTRL_W  = 6,
   parameter int unsigned STAT_W  = 5,
   parameter bit          HAS_VEC = 1'b1,
   parameter int unsigned N_WATCH = 2
) (
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_hit,
   output logic [DATA_W-1:0] wr_mask,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_mask
);
   localparam int unsigned NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] mask_tab [NREG];
   logic [NREG-1:0]   hit_tab;

   for (genvar a = 0; a < NREG; a++) begin : g_slot
      localparam int unsigned W_RAW = slot_width(a, CTRL_W, STAT_W, HAS_VEC, N_WATCH);
      localparam int unsigned W     = (W_RAW > DATA_W) ? DATA_W : W_RAW;
      localparam logic [63:0] M64   = low_ones(W);
      assign mask_tab[a] = M64[DATA_W-1:0];
      assign hit_tab[a]  = (W != 0);
   end

   assign wr_hit  = hit_tab[wr_addr];
   assign wr_mask = mask_tab[wr_addr];
   assign rd_hit  = hit_tab[rd_addr];
   assign rd_mask = mask_tab[rd_addr];
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port
   import dsap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTRL_W    = 6,
   parameter int unsigned STAT_W    = 5,
   parameter bit          HAS_VEC   = 1'b1,
   parameter int unsigned N_WATCH   = 2,
   parameter int unsigned SAFE_ADDR = SAFE_SLOT,
   localparam int unsigned NREG     = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_dr,
   input  logic              shift_dr,
   input  logic              upd_dr,
   input  logic              tdi,
   output logic              tdo,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [NREG-1:0]   rd_strb_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [NREG-1:0]   wr_strb_o,
   output logic [DATA_W-1:0] wr_data_o
);
   localparam int unsigned CHAIN_W  = DATA_W + ADDR_W + 1;
   localparam int unsigned FLAG_BIT = CHAIN_W - 1;
   localparam int unsigned HDR_W    = CHAIN_W - DATA_W;

   // Elaboration-time parameter checks
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must be 5..8");
   end
   if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W must be 8..64");
   end
   if (CTRL_W < 1 || CTRL_W > DATA_W || STAT_W < 1 || STAT_W > DATA_W) begin : g_bad_w
      $error("CTRL_W and STAT_W must be 1..DATA_W");
   end
   if (N_WATCH > NREG / WATCH_STRIDE - 1) begin : g_bad_watch
      $error("N_WATCH does not fit the address space");
   end
   if (SAFE_ADDR >= NREG ||
       slot_width(SAFE_ADDR, CTRL_W, STAT_W, HAS_VEC, N_WATCH) == 0) begin : g_bad_safe
      $error("SAFE_ADDR must be a mapped address");
   end

   logic [1:0]          evt;
   logic                cap_evt, upd_evt;
   logic [CHAIN_W-1:0]  chain_q, cap_val;
   logic [ADDR_W-1:0]   sc_addr, rd_addr_q;
   logic [DATA_W-1:0]   sc_data, wr_mask, rd_mask, wr_data_q;
   logic                sc_flag, wr_hit, rd_hit;
   logic [NREG-1:0]     wr_strb_q;

   dsap_pulse #(.N(2)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   ({upd_dr, cap_dr}),
      .evt   (evt)
   );
   assign cap_evt = evt[0];
   assign upd_evt = evt[1];

   dsap_shift #(.CHAIN_W(CHAIN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_evt  (cap_evt),
      .shift_en (shift_dr),
      .tdi      (tdi),
      .cap_val  (cap_val),
      .chain_q  (chain_q),
      .tdo      (tdo)
   );

   assign sc_data = chain_q[DATA_W-1:0];
   assign sc_addr = chain_q[DATA_W +: ADDR_W];
   assign sc_flag = chain_q[FLAG_BIT];

   dsap_map #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .CTRL_W  (CTRL_W),
      .STAT_W  (STAT_W),
      .HAS_VEC (HAS_VEC),
      .N_WATCH (N_WATCH)
   ) u_map (
      .wr_addr (sc_addr),
      .rd_addr (rd_addr_q),
      .wr_hit  (wr_hit),
      .wr_mask (wr_mask),
      .rd_hit  (rd_hit),
      .rd_mask (rd_mask)
   );

   // Capture value: header bits zero, data masked, holes read zero.
   assign cap_val = rd_hit ? {{HDR_W{1'b0}}, rd_data_i & rd_mask} : '0;

   // Update handling
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= ADDR_W'(SAFE_ADDR);
         wr_strb_q <= '0;
         wr_data_q <= '0;
      end else begin
         wr_strb_q <= '0;
         if (upd_evt) begin
            if (sc_flag) begin
               if (wr_hit) begin
                  wr_strb_q <= NREG'(1) << sc_addr;
                  wr_data_q <= sc_data & wr_mask;
               end
            end else begin
               rd_addr_q <= sc_addr;
            end
         end
      end
   end

   assign rd_addr_o = rd_addr_q;
   assign rd_strb_o = (cap_evt && rd_hit) ? (NREG'(1) << rd_addr_q) : '0;
   assign wr_strb_o = wr_strb_q;
   assign wr_data_o = wr_data_q;
endmodule

// File: rtl/dsap_checker.sv
module dsap_checker
   import dsap_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned CTRL_W  = 6,
   parameter int unsigned STAT_W  = 5,
   parameter bit          HAS_VEC = 1'b1,
   parameter int unsigned N_WATCH = 2,
   localparam int unsigned NREG   = 1 << ADDR_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cap_dr,
   input logic            upd_dr,
   input logic [NREG-1:0] rd_strb_o,
   input logic [NREG-1:0] wr_strb_o
);
   logic [NREG-1:0] mapped;
   for (genvar a = 0; a < NREG; a++) begin : g_m
      assign mapped[a] = (slot_width(a, CTRL_W, STAT_W, HAS_VEC, N_WATCH) != 0);
   end

   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_strb_o)); // R2
   AST_WR_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb_o != '0) |-> $past(upd_dr)); // R2
   AST_WR_MAPPED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb_o & ~mapped) == '0); // R3
   AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_strb_o)); // R5
   AST_RD_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strb_o != '0) |-> cap_dr); // R5
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strb_o != '0) |=> (rd_strb_o == '0)); // R7
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strb_o != '0) |=> (wr_strb_o == '0)); // R7
endmodule

bind dbg_scan_port dsap_checker #(
   .ADDR_W  (ADDR_W),
   .CTRL_W  (CTRL_W),
   .STAT_W  (STAT_W),
   .HAS_VEC (HAS_VEC),
   .N_WATCH (N_WATCH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cap_dr    (cap_dr),
   .upd_dr    (upd_dr),
   .rd_strb_o (rd_strb_o),
   .wr_strb_o (wr_strb_o)
);

// File: tb/dbg_scan_port_tb_top.sv
module dbg_scan_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
   logic        tdo;
   logic [4:0]  rd_addr_o;
   logic [31:0] rd_strb_o, wr_strb_o, wr_data_o, rd_data_i;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] bank  [32];
   logic [31:0] mbank [32];
   int exp_rd_addr;

   always #5 clk = ~clk;

   dbg_scan_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_dr    (cap_dr),
      .shift_dr  (shift_dr),
      .upd_dr    (upd_dr),
      .tdi       (tdi),
      .tdo       (tdo),
      .rd_addr_o (rd_addr_o),
      .rd_strb_o (rd_strb_o),
      .rd_data_i (rd_data_i),
      .wr_strb_o (wr_strb_o),
      .wr_data_o (wr_data_o)
   );

   // Behavioural register bank
   assign rd_data_i = bank[rd_addr_o];
   always @(posedge clk) begin
      for (int i = 0; i < 32; i++)
         if (wr_strb_o[i]) bank[i] <= wr_data_o;
   end

   function automatic int exp_width(input int a);
      case (a)
         0: return 6;
         1: return 5;
         2: return 8;
         4: return 6;
         5: return 32;
         8, 9, 10, 11, 16, 17, 18, 19: return 32;
         12, 20: return 9;
         13, 21: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_mask(input int a);
      int w;
      w = exp_width(a);
      if (w >= 32) return 32'hFFFF_FFFF;
      return (32'd1 << w) - 32'd1;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run_scan(input logic [37:0] din, input int cap_n, input int upd_n,
                           input string ctag);
      logic [37:0] dout;
      logic [31:0] rd_seen, wr_seen, wdat;
      int rd_cnt, wr_cnt, a;
      logic [37:0] e_dout;
      logic [31:0] e_rd, e_wr, e_wdat;
      string t_cap;
      rd_seen = '0; wr_seen = '0; wdat = '0; rd_cnt = 0; wr_cnt = 0; dout = '0;
      // expectations for the capture half
      if (exp_width(exp_rd_addr) != 0) begin
         e_dout = {6'b0, mbank[exp_rd_addr] & exp_mask(exp_rd_addr)};
         e_rd   = 32'd1 << exp_rd_addr;
         t_cap  = (exp_mask(exp_rd_addr) != 32'hFFFF_FFFF) ? "R8" : "R4";
      end else begin
         e_dout = '0;
         e_rd   = '0;
         t_cap  = "R5";
      end
      if (ctag != "") t_cap = ctag;
      // capture
      cap_dr = 1'b1;
      for (int k = 0; k < cap_n; k++) begin
         #1;
         if (rd_strb_o != '0) begin rd_cnt++; rd_seen |= rd_strb_o; end
         @(negedge clk);
      end
      cap_dr = 1'b0;
      shift_dr = 1'b1;
      for (int i = 0; i < 38; i++) begin
         dout[i] = tdo;
         tdi = din[i];
         @(negedge clk);
      end
      shift_dr = 1'b0;
      chk("R1 chain holds shifted word", {63'd0, tdo}, {63'd0, din[0]});
      upd_dr = 1'b1;
      for (int k = 0; k < upd_n; k++) begin
         @(negedge clk);
         if (wr_strb_o != '0) begin wr_cnt++; wr_seen |= wr_strb_o; wdat = wr_data_o; end
      end
      upd_dr = 1'b0;
      @(negedge clk);
      if (wr_strb_o != '0) begin wr_cnt++; wr_seen |= wr_strb_o; end
      chk({t_cap, " captured word"}, {26'd0, dout}, {26'd0, e_dout});
      chk("R5 read strobe", {32'd0, rd_seen}, {32'd0, e_rd});
      chk("R7 read pulses", 64'(rd_cnt), (e_rd != 0) ? 64'd1 : 64'd0);
      // expectations for the update half
      a = int'(din[36:32]);
      if (din[37]) begin
         e_wr   = (exp_width(a) != 0) ? (32'd1 << a) : '0;
         e_wdat = din[31:0] & exp_mask(a);
         chk((e_wr != 0) ? "R2 write strobe" : "R3 write strobe", {32'd0, wr_seen}, {32'd0, e_wr});
         chk("R7 write pulses", 64'(wr_cnt), (e_wr != 0) ? 64'd1 : 64'd0);
         if (e_wr != 0) begin
            chk((exp_mask(a) != 32'hFFFF_FFFF) ? "R8 write data" : "R2 write data",
                {32'd0, wdat}, {32'd0, e_wdat});
            mbank[a] = e_wdat;
         end
      end else begin
         chk("R4 no write on read", {32'd0, wr_seen}, 64'd0);
         chk("R4 read address", {59'd0, rd_addr_o}, 64'(a));
         exp_rd_addr = a;
      end
   endtask

   function automatic logic [37:0] mk(input bit wr, input int a, input logic [31:0] d);
      return {wr, 5'(a), d};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 32; i++) begin
         bank[i]  = 32'h9E37_79B9 * (i + 1) ^ 32'hF0F0_0F0F;
         mbank[i] = bank[i];
      end
      exp_rd_addr = 4;
      repeat (3) @(negedge clk);
      chk("R6 tdo in reset", {63'd0, tdo}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset read address", {59'd0, rd_addr_o}, 64'd4);
      chk("R6 no write strobe", {32'd0, wr_strb_o}, 64'd0);
      chk("R6 no read strobe", {32'd0, rd_strb_o}, 64'd0);
      chk("R6 tdo after reset", {63'd0, tdo}, 64'd0);
      // directed corners
      run_scan(mk(0, 5, 32'h1234_5678), 1, 1, "R6");
      run_scan(mk(1, 12, 32'hFFFF_FFFF), 1, 1, "");
      run_scan(mk(0, 12, 32'h0), 1, 1, "");
      run_scan(mk(1, 3, 32'hDEAD_BEEF), 1, 1, "");
      run_scan(mk(1, 30, 32'hCAFE_F00D), 2, 3, "");
      run_scan(mk(0, 3, 32'h0), 1, 1, "");
      run_scan(mk(0, 5, 32'h0), 1, 1, "");
      run_scan(mk(1, 5, 32'hA5A5_5A5A), 3, 3, "");
      run_scan(mk(0, 1, 32'h0), 3, 1, "");
      run_scan(mk(1, 0, 32'hFFFF_FFEF), 1, 2, "");
      run_scan(mk(0, 0, 32'h0), 1, 1, "");
      run_scan(mk(0, 4, 32'h0), 1, 1, "");
      // constrained random
      for (int n = 0; n < 400; n++) begin
         int a;
         logic [31:0] d;
         bit wr;
         if (($urandom % 10) < 7) begin
            int sel;
            sel = int'($urandom % 16);
            a = (sel < 6) ? ((sel == 3) ? 5 : sel) : ((sel < 11) ? (8 + sel - 6) : (16 + sel - 11));
         end else begin
            a = int'($urandom % 32);
         end
         d  = $urandom;
         wr = bit'($urandom % 2);
         run_scan(mk(wr, a, d), 1 + int'($urandom % 3), 1 + int'($urandom % 3), "");
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule